// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a clocked model of a static RAM with bursts. The data word is 36 bits wide and is split into four 9-bit byte lanes. Every control, address and data input is captured on the rising clock edge. An access starts on one of two start strobes. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, chosen by the write controls. Follow-on beats of a burst take their two lowest address bits from an internal 2-bit counter, which steps in either linear or interleaved order. The advance input can hold the counter in wait cycles.

Reads are flow-through: once an edge has set the current address, the stored word at that address appears on the read port. The output drive is modelled as a data bus and a separate drive-enable flag, and the output enable acts on it combinationally. A sleep input freezes the whole block and turns the output drive off.

Top module: `burst_sram`

## Requirements
- R1: Inputs act only at the rising edge of clk_i. A change in addr_i or in the strobes between edges leaves rdata_o and dq_oe_o unchanged until the next edge.
- R2: The device counts as selected only when sel_ni is 0 and sel_i is 1 at the same edge.
- R3: An edge with proc_start_ni=0 and sel_ni=0 loads addr_i and starts a read when sel_i=1, whatever the write controls are. With sel_i=0 it deselects the device. With sel_ni=1 the processor strobe has no effect.
- R4: An edge with ctrl_start_ni=0, and no processor start, loads addr_i and writes the word at that address when the device is selected and a write control is active. When the device is not selected, the edge deselects it.
- R5: While the device is active and no strobe is asserted, advance_ni=0 steps the burst counter by one beat. advance_ni=1 holds the address for a wait cycle. A write in either kind of cycle goes to the address the edge has just set.
- R6: During a burst, addr bits above bit 1 keep the loaded value. The counter wraps after four beats, so the fifth beat returns to the start address.
- R7: With mode_i=0 (linear), beat k uses low bits (start+k) mod 4. For example, a start of 1 gives 1,2,3,0.
- R8: With mode_i=1 (interleaved), beat k uses low bits start XOR k. For example, a start of 1 gives 1,0,3,2.
- R9: wr_all_ni=0 writes all 36 bits, whatever byte_wr_en_ni and lane_wr_ni are.
- R10: When byte_wr_en_ni=0, each lane_wr_ni[i]=0 writes data bits [9i+8:9i] only. Lane 0 is the lowest byte and lane 3 the highest.
- R11: dq_oe_o is 1 only when out_en_ni=0, the device is active, the last edge was not a write, and sleep_i=0. This output path is combinational. rdata_o is the stored word at the current address while dq_oe_o=1, and zero otherwise.
- R12: When both strobes are 0 at one edge and sel_ni=0, the processor strobe wins, and no write takes place.
- R13: While sleep_i=1, edges change neither state nor memory, and dq_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address |
| wdata_i | input | 36 | Write data |
| sel_ni | input | 1 | Chip select, active low; also gates the processor strobe |
| sel_i | input | 1 | Chip select, active high |
| proc_start_ni | input | 1 | Processor-side start strobe, read only |
| ctrl_start_ni | input | 1 | Controller-side start strobe, read or write |
| advance_ni | input | 1 | Step the burst counter; high gives a wait cycle |
| wr_all_ni | input | 1 | Full-word write, active low |
| byte_wr_en_ni | input | 1 | Enables the per-lane write lines, active low |
| lane_wr_ni | input | 4 | Per-lane write lines, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_ni | input | 1 | Output enable, active low, combinational |
| sleep_i | input | 1 | Low-power freeze, active high |
| rdata_o | output | 36 | Read data, zero while not driving |
| dq_oe_o | output | 1 | Read data drive enable |

## Verification
On every cycle, the assertions check the following: the address holds in wait cycles and sleep cycles, the upper bits stay fixed during a burst, a processor start selects and never writes, a controller strobe without selection deselects, a full-word write enables all lanes, and the drive is off after a write. The order of the burst data, the wrap after four beats, writes that touch only some lanes, strobe priority and the state kept across sleep can only be seen through the bench's write-then-read scenarios. The bench compares these against its behavioural model on every clock.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned DATA_W = LANES * LANE_W;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] cur_addr_o,
  output logic [AW-1:0] nxt_addr_o
);
  import burst_sram_pkg::*;

  logic [AW-1:0] base_q, base_d;
  logic [1:0]    beat_q, beat_d;

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, logic [1:0] k, logic m);
    logic [1:0] lo;
    lo = (burst_order_e'(m) == ORDER_XOR) ? (b[1:0] ^ k) : (b[1:0] + k);
    return {b[AW-1:2], lo};
  endfunction

  always_comb begin
    base_d = load_i ? addr_i : base_q;
    beat_d = load_i ? 2'd0 : (step_i ? beat_q + 2'd1 : beat_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (en_i) begin
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end

  assign cur_addr_o = beat_addr(base_q, beat_q, mode_i);
  assign nxt_addr_o = beat_addr(base_d, beat_d, mode_i);

  // upper bits never move without a load
  assert_upper_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> (cur_addr_o[AW-1:2] == $past(cur_addr_o[AW-1:2])));
endmodule

// File: rtl/lane_we_decode.sv
module lane_we_decode (
  input  logic       wr_all_ni,
  input  logic       byte_wr_en_ni,
  input  logic [3:0] lane_wr_ni,
  output logic [3:0] lane_we_o
);
  always_comb begin
    for (int i = 0; i < 4; i++)
      lane_we_o[i] = !wr_all_ni || (!byte_wr_en_ni && !lane_wr_ni[i]);
  end
endmodule

// File: rtl/lane_array.sv
module lane_array #(
  parameter int unsigned AW = 8
) (
  input  logic                                clk_i,
  input  logic [burst_sram_pkg::LANES-1:0]    we_i,
  input  logic [AW-1:0]                       waddr_i,
  input  logic [burst_sram_pkg::DATA_W-1:0]   wdata_i,
  input  logic [AW-1:0]                       raddr_i,
  output logic [burst_sram_pkg::DATA_W-1:0]   rdata_o
);
  import burst_sram_pkg::*;
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [35:0]   wdata_i,
  input  logic          sel_ni,
  input  logic          sel_i,
  input  logic          proc_start_ni,
  input  logic          ctrl_start_ni,
  input  logic          advance_ni,
  input  logic          wr_all_ni,
  input  logic          byte_wr_en_ni,
  input  logic [3:0]    lane_wr_ni,
  input  logic          mode_i,
  input  logic          out_en_ni,
  input  logic          sleep_i,
  output logic [35:0]   rdata_o,
  output logic          dq_oe_o
);
  import burst_sram_pkg::*;

  logic          en, selected, p_start, c_start, load, step, wr_now;
  logic          active_q, active_d, wr_q;
  logic [3:0]    lane_we, mem_we;
  logic [AW-1:0] cur_addr, nxt_addr;
  logic [35:0]   rd_word;

  assign en       = !sleep_i;
  assign selected = !sel_ni && sel_i;
  assign p_start  = !proc_start_ni && !sel_ni;
  assign c_start  = !ctrl_start_ni && !p_start;
  assign load     = (p_start && sel_i) || (c_start && selected);
  assign step     = !p_start && !c_start && active_q && !advance_ni;

  always_comb begin
    if (p_start)      active_d = sel_i;
    else if (c_start) active_d = selected;
    else              active_d = active_q;
  end

  // processor start is read-only; write needs an active target after the edge
  assign wr_now = en && (|lane_we) &&
                  ((c_start && selected) || (!p_start && !c_start && active_q));
  assign mem_we = wr_now ? lane_we : 4'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
    end else if (en) begin
      active_q <= active_d;
      wr_q     <= wr_now;
    end
  end

  burst_seq #(.AW(AW)) u_seq (
    .clk_i, .rst_ni, .en_i(en), .load_i(load), .step_i(step), .mode_i,
    .addr_i, .cur_addr_o(cur_addr), .nxt_addr_o(nxt_addr)
  );

  lane_we_decode u_dec (
    .wr_all_ni, .byte_wr_en_ni, .lane_wr_ni, .lane_we_o(lane_we)
  );

  lane_array #(.AW(AW)) u_mem (
    .clk_i, .we_i(mem_we), .waddr_i(nxt_addr), .wdata_i,
    .raddr_i(cur_addr), .rdata_o(rd_word)
  );

  assign dq_oe_o = !out_en_ni && active_q && !wr_q && !sleep_i;
  assign rdata_o = dq_oe_o ? rd_word : '0;

  assert_wait_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && active_q && proc_start_ni && ctrl_start_ni && advance_ni) |=> $stable(cur_addr));
  assert_proc_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_start && sel_i && en) |-> (mem_we == 4'b0) ##1 active_q);
  assert_ctrl_desel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !ctrl_start_ni && proc_start_ni && !selected) |=> !active_q);
  assert_full_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && active_q && proc_start_ni && ctrl_start_ni && !wr_all_ni) |-> (mem_we == 4'hf));
  assert_sleep_freeze_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (mem_we == 4'b0) ##1 ($stable(cur_addr) && $stable(active_q)));
  assert_no_drive_after_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_now && !sleep_i) |=> !dq_oe_o);
endmodule

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
  localparam int AW = 8;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [35:0]   wdata = '0;
  logic sel_n = 1, sel = 0, ps_n = 1, cs_n = 1, adv_n = 1, wall_n = 1, ben_n = 1;
  logic [3:0] lane_n = 4'hf;
  logic mode = 0, oe_n = 0, zz = 0;
  logic [35:0] rdata;
  logic        dq_oe;

  always #2 clk = ~clk;

  burst_sram #(.AW(AW)) u_burst_sram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .sel_ni(sel_n),
    .sel_i(sel), .proc_start_ni(ps_n), .ctrl_start_ni(cs_n), .advance_ni(adv_n),
    .wr_all_ni(wall_n), .byte_wr_en_ni(ben_n), .lane_wr_ni(lane_n), .mode_i(mode),
    .out_en_ni(oe_n), .sleep_i(zz), .rdata_o(rdata), .dq_oe_o(dq_oe)
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [35:0] rm [0:255];
  bit   [3:0]  rv [0:255];
  bit          m_act = 0, m_wr = 0;
  int          m_base = 0, m_beat = 0;

  function automatic int m_addr();
    int lo = mode ? ((m_base % 4) ^ m_beat) : ((m_base % 4 + m_beat) % 4);
    return (m_base / 4) * 4 + lo;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_wr = 0; m_base = 0; m_beat = 0;
    end else if (!zz) begin
      bit do_w, sl;
      bit [3:0] we;
      do_w = 0;
      sl = !sel_n && sel;
      for (int i = 0; i < 4; i++) we[i] = !wall_n || (!ben_n && !lane_n[i]);
      if (!ps_n && !sel_n) begin
        m_act = sel;
        if (sel) begin m_base = addr; m_beat = 0; end
      end else if (!cs_n) begin
        m_act = sl;
        if (sl) begin m_base = addr; m_beat = 0; do_w = 1; end
      end else if (m_act) begin
        if (!adv_n) m_beat = (m_beat + 1) % 4;
        do_w = 1;
      end
      do_w = do_w && (we != 0);
      if (do_w) begin
        int a = m_addr();
        for (int i = 0; i < 4; i++)
          if (we[i]) begin rm[a][i*9 +: 9] = wdata[i*9 +: 9]; rv[a][i] = 1; end
      end
      m_wr = do_w;
    end
  end

  task automatic compare();
    bit exp_oe = !oe_n && m_act && !m_wr && !zz;
    checks++;
    if (dq_oe !== exp_oe) begin
      fails++;
      $display("FAIL %s: dq_oe act=%b exp=%b", cur_req, dq_oe, exp_oe);
    end else if (exp_oe) begin
      int a = m_addr();
      for (int i = 0; i < 4; i++)
        if (rv[a][i] && rdata[i*9 +: 9] !== rm[a][i*9 +: 9]) begin
          fails++;
          $display("FAIL %s: lane %0d act=%h exp=%h", cur_req, i, rdata[i*9 +: 9], rm[a][i*9 +: 9]);
        end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic chk(string req, logic oe_e, logic [35:0] d_e);
    checks++;
    if (dq_oe !== oe_e || (oe_e && rdata !== d_e)) begin
      fails++;
      $display("FAIL %s: oe=%b data=%h exp oe=%b data=%h", req, dq_oe, rdata, oe_e, d_e);
    end
  endtask

  task automatic idle();
    ps_n = 1; cs_n = 1; adv_n = 1; wall_n = 1; ben_n = 1; lane_n = 4'hf;
  endtask

  function automatic logic [35:0] dv(int i);
    return 36'hA5A5A5A50 + 36'(i * 36'h111);
  endfunction

  bit done = 0;
  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1; chk("R11 reset", 1'b0, '0);
    #8 rst_n = 1;
    tick();
    // R4 R9 R5: controller start write burst 0x10..0x13, full-word writes
    cur_req = "R4";
    sel_n = 0; sel = 1; cs_n = 0; addr = 8'h10; wall_n = 0; wdata = dv(0);
    tick();
    chk("R11 no drive after write", 1'b0, '0);
    cs_n = 1; adv_n = 0;
    for (int i = 1; i < 4; i++) begin wdata = dv(i); tick(); end
    idle(); tick();
    // R7 linear read from 0x11
    cur_req = "R7"; mode = 0; ps_n = 0; addr = 8'h11; wall_n = 0;
    tick();
    chk("R3 read despite write ctl", 1'b1, dv(1));
    ps_n = 1; wall_n = 1; adv_n = 0;
    tick(); chk("R7 beat1", 1'b1, dv(2));
    tick(); chk("R7 beat2", 1'b1, dv(3));
    tick(); chk("R7 beat3", 1'b1, dv(0));
    tick(); chk("R6 wrap", 1'b1, dv(1));
    // R5 wait
    cur_req = "R5"; adv_n = 1;
    tick(); chk("R5 wait hold", 1'b1, dv(1));
    // R1: inputs mid-cycle have no effect
    addr = 8'h13; ps_n = 0; #1;
    chk("R1 mid-cycle", 1'b1, dv(1));
    // R8 interleaved from 0x11
    cur_req = "R8"; mode = 1;
    tick(); chk("R1 load at edge", 1'b1, dv(3));
    addr = 8'h11; tick();
    ps_n = 1; adv_n = 0;
    tick(); chk("R8 beat1", 1'b1, dv(0));
    tick(); chk("R8 beat2", 1'b1, dv(3));
    tick(); chk("R8 beat3", 1'b1, dv(2));
    mode = 0; idle();
    // R10 byte lanes 0 and 2 into 0x20 over prior full word
    cur_req = "R10"; cs_n = 0; addr = 8'h20; wall_n = 0; wdata = 36'h0;
    tick();
    cs_n = 1; wall_n = 1; ben_n = 0; lane_n = 4'b1010; wdata = 36'hFFFFFFFFF;
    tick();
    idle(); ps_n = 0; tick();
    chk("R10 lanes 0,2", 1'b1, 36'h007FC01FF);
    ps_n = 1; ben_n = 1; lane_n = 4'h0; tick();
    chk("R10 lines need enable", 1'b1, 36'h007FC01FF);
    // R12 both strobes, write ctl on: read wins
    cur_req = "R12"; ps_n = 0; cs_n = 0; addr = 8'h10; wall_n = 0; wdata = 36'h123456789;
    tick(); chk("R12 proc wins", 1'b1, dv(0));
    idle(); tick(); chk("R12 no write", 1'b1, dv(0));
    // R13 sleep: ignore write start
    cur_req = "R13"; zz = 1; cs_n = 0; addr = 8'h12; wall_n = 0; wdata = 36'h0;
    tick(); chk("R13 no drive", 1'b0, '0);
    idle(); zz = 0; #1;
    chk("R13 state kept", 1'b1, dv(0));
    ps_n = 0; addr = 8'h12; tick(); chk("R13 memory kept", 1'b1, dv(2));
    // R11 output enable combinational
    cur_req = "R11"; idle(); oe_n = 1; #1;
    chk("R11 oe off", 1'b0, '0);
    oe_n = 0; #1; chk("R11 oe on", 1'b1, dv(2));
    // R3: proc start with sel_i low deselects; with sel_ni high ignored
    cur_req = "R3"; tick();
    sel_n = 1; ps_n = 0; addr = 8'h13; tick();
    chk("R3 ignored when sel_n high", 1'b1, dv(2));
    sel_n = 0; sel = 0; tick();
    chk("R3 deselect", 1'b0, '0);
    // R2 / R4: controller start with partial select deselects
    cur_req = "R2"; sel = 1; tick(); idle();
    chk("R2 reselect", 1'b1, dv(3));
    sel_n = 1; cs_n = 0; tick();
    chk("R2 R4 deselect", 1'b0, '0);
    idle(); tick();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule